// File: doc/BRIEF.md
# Indexed Audio Codec Control Register Interface

This block is the host-facing register front end of an audio codec. The host sees only four byte-wide locations, selected by the two low address bits. One location holds a pointer. A second reaches, through that pointer, a bank of 32 indirect 8-bit control registers. A third is an interrupt status byte, and the fourth is a programmed-I/O data byte that always reads as zero. How much of the pointer is decoded depends on an extended-mode bit held in indirect register 12. In the base mode only the 16 low registers are visible.

Several indirect registers carry protection rules. Some are reserved or read-only. The mode register changes in one bit only. The interface-configuration register drops one bit on every write. The playback-format register accepts a write only while the pointer's mode-change-enable bit is set, or, in a reduced form, while the playback-interrupt flag is set. When mode-change-enable rises while calibration is configured, a short busy indication appears: for a fixed number of reads, the read-only status register 11 shows its calibration-busy bit. A one-cycle completion pulse from the playback engine raises an interrupt. The host clears it by writing the status location, or by clearing the playback-interrupt flag in register 24.

The block also drives the playback engine with the control fields it needs: the sample format, the interface configuration, the pin control, the 16-bit playback count and the extended-mode flag.

Top module: `codec_regif`

## Requirements
- R1: `bus_addr` selects the location: 0 is the pointer, 1 is the indirect data, 2 is the status byte ({7'b0, int flag}) and 3 is the PIO data. Location 3 always reads 0x00, and writes to it change nothing.
- R2: The pointer resets to 0x40, so mode-change-enable (bit 6) is set. A write stores bits 6:0, and bit 7 always reads as 0.
- R3: While bit 6 of register 12 is clear, pointer bits 3:0 select the indirect register. While it is set, bits 4:0 select it.
- R4: After reset, registers 2–5 and 18–19 hold 0x88, registers 6–7 hold 0x80, register 9 holds 0x08, register 12 holds 0x8A, registers 25–26 hold 0xA0, and every other register holds 0x00.
- R5: Writes to registers 11, 22, 27 and 29 leave them unchanged.
- R6: A write to register 12 changes only its bit 6.
- R7: A pointer write that takes bit 6 from 0 to 1 while register 9 bits 4:3 are non-zero loads a busy counter with CAL_READS (1 by default). Each read of register 11 while the counter is non-zero returns bit 5 set and decrements the counter. If bits 4:3 of register 9 are both zero, the counter is not loaded.
- R8: A write to register 8 is stored whole while pointer bit 6 is set. If pointer bit 6 is clear and register 24 bit 4 is set, the register takes the new bits 7:4 and keeps its old bits 3:0. In every other case the write is dropped.
- R9: A write to register 9 stores bit 5 as 0.
- R10: A `play_done` pulse sets the status int flag, register 24 bit 4 and `irq_o` at the next clock edge.
- R11: Any write to location 2 clears the int flag, `irq_o` and bits 6:4 of register 24. If a `play_done` pulse arrives in the same cycle, the pulse wins.
- R12: A write to register 24 that takes bit 4 from 1 to 0 clears the int flag and `irq_o`. A write that leaves bit 4 at 1 does not.
- R13: `play_fmt_o`, `iface_cfg_o` and `pin_ctl_o` mirror registers 8, 9 and 10. `play_count_o` is {register 14, register 15}, and `ext_mode_o` is register 12 bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Direct location select |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, valid in the cycle `bus_rd` is high |
| play_done | input | 1 | Playback-count-complete pulse from the playback engine |
| irq_o | output | 1 | Interrupt request |
| play_fmt_o | output | 8 | Playback sample format (register 8) |
| iface_cfg_o | output | 8 | Interface configuration (register 9) |
| pin_ctl_o | output | 8 | Pin control (register 10) |
| play_count_o | output | 16 | Playback base count |
| ext_mode_o | output | 1 | Extended-mode flag |

## Verification
Read data is a combinational view of the registered state, so it is due in the same cycle as the read strobe. Every write side effect is due at the first clock edge after the strobe: the pointer, the indirect registers, the busy counter and the decrement that a read causes. `irq_o` and the exported fields are flop outputs and change at that same edge. The bench therefore drives each strobe on a falling edge and samples read data one nanosecond later, before the next rising edge. It looks at `irq_o` and the exported fields only at the falling edge after the access or pulse has completed.

// File: rtl/codec_regif_pkg.sv
package codec_regif_pkg;

  localparam int DW = 8;

  // direct locations
  localparam logic [1:0] LOC_PTR  = 2'd0;
  localparam logic [1:0] LOC_DATA = 2'd1;
  localparam logic [1:0] LOC_STAT = 2'd2;
  localparam logic [1:0] LOC_PIO  = 2'd3;

  // indirect register numbers the logic depends on
  localparam int REG_PFMT    = 8;
  localparam int REG_IFCFG   = 9;
  localparam int REG_PINCTL  = 10;
  localparam int REG_CALSTAT = 11;
  localparam int REG_MODE    = 12;
  localparam int REG_PCNT_HI = 14;
  localparam int REG_PCNT_LO = 15;
  localparam int REG_FLAGS   = 24;

  // bit positions
  localparam int PTR_MCE_BIT   = 6;
  localparam int MODE_EXT_BIT  = 6;
  localparam int FLAG_PI_BIT   = 4;
  localparam int FLAG_LO_BIT   = 4;
  localparam int FLAG_HI_BIT   = 6;
  localparam int CAL_BUSY_BIT  = 5;
  localparam int IFCFG_DROP_BIT = 5;

  function automatic logic [DW-1:0] reg_reset_val(input int n);
    case (n)
      2, 3, 4, 5, 18, 19: return 8'h88;
      6, 7:               return 8'h80;
      9:                  return 8'h08;
      12:                 return 8'h8A;
      25, 26:             return 8'hA0;
      default:            return 8'h00;
    endcase
  endfunction

  // bits a host write may change in each register
  function automatic logic [DW-1:0] reg_wr_mask(input int n);
    case (n)
      REG_CALSTAT, 22, 27, 29: return 8'h00;
      REG_MODE:                return 8'h40;
      REG_IFCFG:               return 8'hDF;
      default:                 return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/codec_index_ctl.sv
module codec_index_ctl
  import codec_regif_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int CAL_READS = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [DW-1:0]    wdata,
  input  logic             arm_ok,
  input  logic             cal_rd,
  output logic [DW-1:0]    idx_o,
  output logic [CNT_W-1:0] busy_o
);

  localparam logic [DW-1:0]    PTR_RST  = 8'h40;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CAL_READS);

  logic [DW-1:0]    idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic             mce_rise;

  assign mce_rise = wr_en && !idx_q[PTR_MCE_BIT] && wdata[PTR_MCE_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= PTR_RST;
    end else if (wr_en) begin
      idx_q <= {1'b0, wdata[DW-2:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (mce_rise && arm_ok) begin
      cnt_q <= LOAD_VAL;
    end else if (cal_rd && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign idx_o  = idx_q;
  assign busy_o = cnt_q;

endmodule

// File: rtl/codec_ind_bank.sv
module codec_ind_bank
  import codec_regif_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int IW = $clog2(NUM_REGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] sel,
  input  logic [DW-1:0] wdata,
  input  logic          mce,
  input  logic          flag_clr,
  input  logic          pi_set,
  output logic [DW-1:0] regs_o [NUM_REGS],
  output logic          pi_fall_o
);

  logic [DW-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [DW-1:0] RV = reg_reset_val(g);
    localparam logic [DW-1:0] WM = reg_wr_mask(g);
    logic          hit;
    logic [DW-1:0] nxt;

    assign hit = wr_en && (sel == IW'(g));

    always_comb begin
      nxt = regs_q[g];
      if (hit) begin
        if (g == REG_PFMT) begin
          if (mce) begin
            nxt = wdata;
          end else if (regs_q[REG_FLAGS][FLAG_PI_BIT]) begin
            nxt = {wdata[DW-1:4], regs_q[g][3:0]};
          end
        end else begin
          nxt = (regs_q[g] & ~WM) | (wdata & WM);
        end
      end
      if (g == REG_FLAGS) begin
        if (flag_clr) nxt[FLAG_HI_BIT:FLAG_LO_BIT] = '0;
        if (pi_set)   nxt[FLAG_PI_BIT] = 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) regs_q[g] <= RV;
      else     regs_q[g] <= nxt;
    end
  end

  assign pi_fall_o = wr_en && (sel == IW'(REG_FLAGS))
                     && regs_q[REG_FLAGS][FLAG_PI_BIT] && !wdata[FLAG_PI_BIT];

  assign regs_o = regs_q;

endmodule

// File: rtl/codec_int_ctl.sv
module codec_int_ctl (
  input  logic clk,
  input  logic rst,
  input  logic set_ev,
  input  logic clr_ev,
  output logic int_o
);

  logic int_q;

  always_ff @(posedge clk) begin
    if (rst)         int_q <= 1'b0;
    else if (set_ev) int_q <= 1'b1;
    else if (clr_ev) int_q <= 1'b0;
  end

  assign int_o = int_q;

endmodule

// File: rtl/codec_regif.sv
module codec_regif
  import codec_regif_pkg::*;
#(
  parameter int NUM_REGS  = 32,
  parameter int CNT_W     = 4,
  parameter int CAL_READS = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  input  logic        bus_wr,
  input  logic        bus_rd,
  output logic [7:0]  bus_rdata,
  input  logic        play_done,
  output logic        irq_o,
  output logic [7:0]  play_fmt_o,
  output logic [7:0]  iface_cfg_o,
  output logic [7:0]  pin_ctl_o,
  output logic [15:0] play_count_o,
  output logic        ext_mode_o
);

  localparam int IW     = $clog2(NUM_REGS);
  localparam int BASE_W = IW - 1;

  logic [DW-1:0]    idx_q;
  logic [CNT_W-1:0] busy_cnt;
  logic [DW-1:0]    regs [NUM_REGS];
  logic [IW-1:0]    sel;
  logic             ext_mode;
  logic             wr_ptr, wr_data, wr_stat, cal_rd, arm_ok;
  logic             pi_fall, int_flag;

  assign ext_mode = regs[REG_MODE][MODE_EXT_BIT];
  assign sel      = ext_mode ? idx_q[IW-1:0] : IW'(idx_q[BASE_W-1:0]);

  assign wr_ptr  = bus_wr && (bus_addr == LOC_PTR);
  assign wr_data = bus_wr && (bus_addr == LOC_DATA);
  assign wr_stat = bus_wr && (bus_addr == LOC_STAT);
  assign cal_rd  = bus_rd && (bus_addr == LOC_DATA) && (sel == IW'(REG_CALSTAT));
  assign arm_ok  = regs[REG_IFCFG][4:3] != 2'b00;

  codec_index_ctl #(
    .CNT_W     (CNT_W),
    .CAL_READS (CAL_READS)
  ) u_index (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_ptr),
    .wdata  (bus_wdata),
    .arm_ok (arm_ok),
    .cal_rd (cal_rd),
    .idx_o  (idx_q),
    .busy_o (busy_cnt)
  );

  codec_ind_bank #(
    .NUM_REGS (NUM_REGS)
  ) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_data),
    .sel       (sel),
    .wdata     (bus_wdata),
    .mce       (idx_q[PTR_MCE_BIT]),
    .flag_clr  (wr_stat),
    .pi_set    (play_done),
    .regs_o    (regs),
    .pi_fall_o (pi_fall)
  );

  codec_int_ctl u_int (
    .clk    (clk),
    .rst    (rst),
    .set_ev (play_done),
    .clr_ev (wr_stat || pi_fall),
    .int_o  (int_flag)
  );

  always_comb begin
    case (bus_addr)
      LOC_PTR:  bus_rdata = idx_q;
      LOC_DATA: begin
        bus_rdata = regs[sel];
        if (sel == IW'(REG_CALSTAT) && busy_cnt != '0)
          bus_rdata[CAL_BUSY_BIT] = 1'b1;
      end
      LOC_STAT: bus_rdata = {7'b0, int_flag};
      default:  bus_rdata = 8'h00;
    endcase
  end

  assign irq_o        = int_flag;
  assign play_fmt_o   = regs[REG_PFMT];
  assign iface_cfg_o  = regs[REG_IFCFG];
  assign pin_ctl_o    = regs[REG_PINCTL];
  assign play_count_o = {regs[REG_PCNT_HI], regs[REG_PCNT_LO]};
  assign ext_mode_o   = ext_mode;

endmodule

// File: rtl/codec_regif_chk.sv
module codec_regif_chk #(
  parameter int IW    = 5,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       bus_addr,
  input logic [7:0]       bus_wdata,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [7:0]       bus_rdata,
  input logic             play_done,
  input logic             irq_o,
  input logic [7:0]       idx_q,
  input logic [IW-1:0]    sel,
  input logic [CNT_W-1:0] busy_cnt,
  input logic [7:0]       reg11,
  input logic [7:0]       reg12
);

  assert_ptr_store_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd0) |=> idx_q == {1'b0, $past(bus_wdata[6:0])});

  assert_pio_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 2'd3) |-> bus_rdata == 8'h00);

  assert_ro_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd1 && sel == IW'(11)) |=> $stable(reg11));

  assert_mode_bits_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd1 && sel == IW'(12))
      |=> (reg12[5:0] == $past(reg12[5:0])) && (reg12[7] == $past(reg12[7])));

  assert_cal_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 2'd1 && sel == IW'(11) && busy_cnt != '0) |-> bus_rdata[5]);

  assert_cal_dec_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 2'd1 && sel == IW'(11) && busy_cnt != '0
     && !(bus_wr && bus_addr == 2'd0)) |=> busy_cnt == $past(busy_cnt) - 1'b1);

  assert_done_irq_R10: assert property (@(posedge clk) disable iff (rst)
    play_done |=> irq_o);

  assert_status_clr_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd2 && !play_done) |=> !irq_o);

endmodule

bind codec_regif codec_regif_chk #(
  .IW    (IW),
  .CNT_W (CNT_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .play_done (play_done),
  .irq_o     (irq_o),
  .idx_q     (idx_q),
  .sel       (sel),
  .busy_cnt  (busy_cnt),
  .reg11     (regs[11]),
  .reg12     (regs[12])
);

// File: tb/codec_regif_tb_top.sv
`timescale 1ns/1ps
module codec_regif_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_addr = 2'd0;
  logic [7:0]  bus_wdata = 8'h00;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic        play_done = 1'b0;
  logic        irq_o;
  logic [7:0]  play_fmt_o, iface_cfg_o, pin_ctl_o;
  logic [15:0] play_count_o;
  logic        ext_mode_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  codec_regif dut_i (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_rdata    (bus_rdata),
    .play_done    (play_done),
    .irq_o        (irq_o),
    .play_fmt_o   (play_fmt_o),
    .iface_cfg_o  (iface_cfg_o),
    .pin_ctl_o    (pin_ctl_o),
    .play_count_o (play_count_o),
    .ext_mode_o   (ext_mode_o)
  );

  function automatic logic [7:0] exp_reset(input int n);
    if (n >= 2 && n <= 5) return 8'h88;
    if (n == 18 || n == 19) return 8'h88;
    if (n == 6 || n == 7) return 8'h80;
    if (n == 9) return 8'h08;
    if (n == 12) return 8'h8A;
    if (n == 25 || n == 26) return 8'hA0;
    return 8'h00;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic sel_reg(input int n, input bit mce);
    bwr(2'd0, {1'b0, mce, 1'b0, 5'(n)});
  endtask

  task automatic iwr(input int n, input bit mce, input logic [7:0] d);
    sel_reg(n, mce);
    bwr(2'd1, d);
  endtask

  task automatic ird(input int n, input bit mce, output logic [7:0] d);
    sel_reg(n, mce);
    brd(2'd1, d);
  endtask

  task automatic pulse_done();
    @(negedge clk);
    play_done = 1'b1;
    @(negedge clk);
    play_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    brd(2'd0, v);  check("R2 pointer reset", v, 8'h40);
    brd(2'd2, v);  check("R1 status reset", v, 8'h00);
    check("R10 irq idle", irq_o, 1'b0);
    check("R13 iface cfg reset", iface_cfg_o, 8'h08);
    check("R13 ext mode reset", ext_mode_o, 1'b0);
    for (int n = 0; n < 16; n++) begin
      ird(n, 1'b1, v);
      check($sformatf("R4 reset reg %0d", n), v, exp_reset(n));
    end
  endtask

  task automatic t_ext_and_upper();
    logic [7:0] v;
    iwr(12, 1'b1, 8'hFF);
    ird(12, 1'b1, v);  check("R6 mode reg only bit6", v, 8'hCA);
    check("R13 ext mode on", ext_mode_o, 1'b1);
    for (int n = 16; n < 32; n++) begin
      ird(n, 1'b1, v);
      check($sformatf("R4 reset reg %0d", n), v, exp_reset(n));
    end
    iwr(12, 1'b1, 8'h00);
    ird(12, 1'b1, v);  check("R6 mode reg cleared bit6", v, 8'h8A);
  endtask

  task automatic t_index_mask();
    logic [7:0] v;
    bwr(2'd0, 8'hFF);
    brd(2'd0, v);  check("R2 pointer bit7 zero", v, 8'h7F);
    iwr(17, 1'b1, 8'h5A);           // base mode: lands in reg 1
    ird(1, 1'b1, v);  check("R3 base mode aliases 17 to 1", v, 8'h5A);
    iwr(12, 1'b1, 8'h40);
    iwr(17, 1'b1, 8'h3C);
    ird(17, 1'b1, v); check("R3 ext mode reaches 17", v, 8'h3C);
    ird(1, 1'b1, v);  check("R3 ext mode reg 1 untouched", v, 8'h5A);
  endtask

  task automatic t_protect();
    logic [7:0] v;
    int ro[4] = '{11, 22, 27, 29};
    foreach (ro[i]) begin
      iwr(ro[i], 1'b1, 8'hFF);
      ird(ro[i], 1'b1, v);
      check($sformatf("R5 protected reg %0d", ro[i]), v, 8'h00);
    end
    iwr(9, 1'b1, 8'hFF);
    ird(9, 1'b1, v);  check("R9 ifcfg bit5 dropped", v, 8'hDF);
    check("R13 iface cfg export", iface_cfg_o, 8'hDF);
  endtask

  task automatic t_cal();
    logic [7:0] v;
    sel_reg(0, 1'b0);
    sel_reg(11, 1'b1);               // rising MCE, reg9[4:3]=11
    brd(2'd1, v);  check("R7 first cal read busy", v, 8'h20);
    brd(2'd1, v);  check("R7 second cal read idle", v, 8'h00);
    iwr(9, 1'b1, 8'h00);
    sel_reg(0, 1'b0);
    sel_reg(11, 1'b1);
    brd(2'd1, v);  check("R7 no arm when cal off", v, 8'h00);
  endtask

  task automatic t_fmt();
    logic [7:0] v;
    iwr(8, 1'b1, 8'h5A);
    ird(8, 1'b1, v);  check("R8 write with MCE", v, 8'h5A);
    check("R13 play fmt export", play_fmt_o, 8'h5A);
    iwr(8, 1'b0, 8'h33);
    ird(8, 1'b0, v);  check("R8 write dropped", v, 8'h5A);
    iwr(24, 1'b0, 8'h10);
    iwr(8, 1'b0, 8'hC7);
    ird(8, 1'b0, v);  check("R8 partial write keeps low", v, 8'hCA);
    iwr(24, 1'b0, 8'h00);
    sel_reg(0, 1'b1);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    pulse_done();
    check("R10 irq raised", irq_o, 1'b1);
    brd(2'd2, v);     check("R10 status int", v, 8'h01);
    ird(24, 1'b1, v); check("R10 flag bit4 set", v, 8'h10);
    iwr(24, 1'b1, 8'h7F);
    check("R12 no clear when bit4 kept", irq_o, 1'b1);
    bwr(2'd2, 8'h00);
    check("R11 irq cleared", irq_o, 1'b0);
    brd(2'd2, v);     check("R11 status cleared", v, 8'h00);
    ird(24, 1'b1, v); check("R11 flags 6:4 cleared", v, 8'h0F);
    pulse_done();
    check("R10 irq raised again", irq_o, 1'b1);
    iwr(24, 1'b1, 8'h00);
    check("R12 irq cleared by flag fall", irq_o, 1'b0);
    brd(2'd2, v);     check("R12 status cleared", v, 8'h00);
  endtask

  task automatic t_pio_export();
    logic [7:0] v;
    iwr(10, 1'b1, 8'h02);
    iwr(14, 1'b1, 8'h12);
    iwr(15, 1'b1, 8'h34);
    check("R13 pin ctl export", pin_ctl_o, 8'h02);
    check("R13 play count export", play_count_o, 16'h1234);
    bwr(2'd3, 8'h55);
    brd(2'd3, v);  check("R1 PIO reads zero", v, 8'h00);
    brd(2'd0, v);  check("R1 pointer unaffected by PIO", v, 8'h4F);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ext_and_upper();
    t_index_mask();
    t_protect();
    t_cal();
    t_fmt();
    t_irq();
    t_pio_export();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule